// File: doc/BRIEF.md
# Paging Control Register Update and Flush Controller

This block keeps the paging-related control state of a processor core: the main control word, the page-directory base, the extension control word and the address-line-20 gate. A single write port with a 2-bit select and 32-bit data updates one register per cycle. The block compares each write against the value it replaces and, where the change touches the bits that affect address translation, raises a one-cycle request to flush the translation cache. That request is either a full flush or a flush that keeps global entries.

The block also keeps a 32-bit physical address mask that follows the address-line-20 gate input. From the main control word it derives five hidden mode flags for the rest of the core. The translation cache and the interrupt logic sit outside; this block only issues request pulses.

A write to the directory base while paging is enabled always requests a non-global flush, even when the value is rewritten unchanged. For the other registers, a write that leaves the relevant bits unchanged produces no pulse.

Top module: `pgctl_top`

## Requirements
- R1: After reset the main control word reads 0x60000010, the directory base and the extension word read 0, the address mask reads 0xFFFFFFFF, the mode flags read 5'b00010, and no request output is high.
- R2: Select 0 writes the main control word. The value stored is the written data with bit 4 forced to 1, and it is visible on the output in the cycle after the write edge.
- R3: A select 0 write pulses flush_all for the following cycle exactly when bit 31 (paging), bit 16 (write protect) or bit 0 (protection enable) of the written data differs from the stored value.
- R4: Mode flag bit 0 mirrors bit 0 of the main control word. Mode flag bit 1 becomes 1 on any main control write with bit 0 clear, and otherwise keeps its value.
- R5: On every main control write, mode flag bits 4:2 take written data bits 3:1.
- R6: Select 1 stores the directory base. flush_keep_global pulses for the following cycle when bit 31 of the main control word was set at the write edge, and it does not pulse otherwise.
- R7: Select 2 stores the extension word. flush_all pulses for the following cycle exactly when bit 7, bit 5 or bit 4 changes.
- R8: When the gate input differs from bit 20 of the address mask, flush_all and exec_exit both pulse for the following cycle. The mask becomes 0xFFEFFFFF with bit 20 equal to the new gate value.
- R9: A write with select 3 changes no register and raises no request.
- R10: Every request is a one-cycle pulse tied to its cause. A write that leaves the flush-relevant bits unchanged, or a steady gate, produces no pulse. Back-to-back qualifying writes give a pulse in each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | 0 main control, 1 directory base, 2 extension word, 3 no register |
| wr_data | input | 32 | Write data |
| a20_gate | input | 1 | Address-line-20 enable |
| ctl_word | output | 32 | Stored main control word |
| dir_base | output | 32 | Stored page-directory base |
| ext_word | output | 32 | Stored extension control word |
| addr_mask | output | 32 | Physical address mask |
| mode_flags | output | 5 | {task switched, emulate, monitor, address segmentation, protected} |
| flush_all | output | 1 | Request a full translation flush |
| flush_keep_global | output | 1 | Request a flush that keeps global entries |
| exec_exit | output | 1 | Request an exit of the current execution |

## Verification
Every result, stored values and request pulses alike, is due exactly one cycle after the rising edge that samples the write or the gate change: one register stage sits between the inputs and each output. The driver stamps each expected item with that due cycle number. The monitor compares only when the bench cycle count reaches that stamp, sampling at the falling edge. An early or late pulse therefore shows up as a mismatch, not as a match in a nearby cycle. Idle cycles carry expectations too, so a stray pulse or a drifting register is caught.

// File: rtl/pgctl_pkg.sv
package pgctl_pkg;
  localparam int REG_W = 32;
  localparam int SEL_W = 2;
  localparam int FLAG_W = 5;

  localparam logic [SEL_W-1:0] SEL_CTL  = 2'd0;
  localparam logic [SEL_W-1:0] SEL_BASE = 2'd1;
  localparam logic [SEL_W-1:0] SEL_EXT  = 2'd2;

  localparam int CTL_PG_BIT = 31;
  localparam int CTL_WP_BIT = 16;
  localparam int CTL_PE_BIT = 0;
  localparam int CTL_ET_BIT = 4;
  localparam int A20_BIT    = 20;

  localparam logic [REG_W-1:0] CTL_RESET    = 32'h6000_0010;
  localparam logic [REG_W-1:0] CTL_FLUSH_GRP = 32'h8001_0001;
  localparam logic [REG_W-1:0] EXT_FLUSH_GRP = 32'h0000_00B0;
  localparam logic [REG_W-1:0] ET_FORCE      = REG_W'(1) << CTL_ET_BIT;
  localparam logic [REG_W-1:0] A20_BIT_MASK  = REG_W'(1) << A20_BIT;

  typedef struct packed {
    logic ts;
    logic em;
    logic mp;
    logic addrseg;
    logic prot;
  } mode_flags_t;

  function automatic logic group_changed(input logic [REG_W-1:0] old_v,
                                         input logic [REG_W-1:0] new_v,
                                         input logic [REG_W-1:0] grp);
    return |((old_v ^ new_v) & grp);
  endfunction

  function automatic logic [REG_W-1:0] ctl_store(input logic [REG_W-1:0] d);
    return d | ET_FORCE;
  endfunction

  function automatic mode_flags_t next_flags(input mode_flags_t prev,
                                             input logic [REG_W-1:0] d);
    mode_flags_t f;
    f.prot    = d[CTL_PE_BIT];
    f.addrseg = prev.addrseg | ~d[CTL_PE_BIT];
    f.mp      = d[1];
    f.em      = d[2];
    f.ts      = d[3];
    return f;
  endfunction

  function automatic logic [REG_W-1:0] gate_mask(input logic g);
    return ~A20_BIT_MASK | ({{(REG_W-1){1'b0}}, g} << A20_BIT);
  endfunction
endpackage

// File: rtl/pgctl_ctl_unit.sv
module pgctl_ctl_unit
  import pgctl_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] ctl_q,
  output mode_flags_t  flags_q,
  output logic         flush_q
);
  mode_flags_t flags_rst;
  logic        flush_need;

  always_comb begin
    flags_rst         = '0;
    flags_rst.addrseg = 1'b1;
    flush_need        = we && group_changed(ctl_q, wdata, CTL_FLUSH_GRP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q   <= CTL_RESET;
      flags_q <= flags_rst;
      flush_q <= 1'b0;
    end else begin
      flush_q <= flush_need;
      if (we) begin
        ctl_q   <= ctl_store(wdata);
        flags_q <= next_flags(flags_q, wdata);
      end
    end
  end

  assert_et_stored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (ctl_q[CTL_ET_BIT] && ctl_q[W-1:CTL_ET_BIT+1] == $past(wdata[W-1:CTL_ET_BIT+1])));

  assert_flush_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |-> ($past(we) && (((ctl_q ^ $past(ctl_q)) & CTL_FLUSH_GRP) != '0)));

  assert_flush_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (((ctl_q ^ $past(ctl_q)) & CTL_FLUSH_GRP) != '0) |-> flush_q);

  assert_prot_mirror_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q.prot == ctl_q[CTL_PE_BIT]) && (!ctl_q[CTL_PE_BIT] -> flags_q.addrseg));

  assert_fpu_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    {flags_q.ts, flags_q.em, flags_q.mp} == ctl_q[3:1]);
endmodule

// File: rtl/pgctl_aux_unit.sv
module pgctl_aux_unit
  import pgctl_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         base_we,
  input  logic         ext_we,
  input  logic         paging_on,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] base_q,
  output logic [W-1:0] ext_q,
  output logic         flush_all_q,
  output logic         flush_ng_q
);
  logic ext_change;
  logic base_flush;

  always_comb begin
    ext_change = ext_we && group_changed(ext_q, wdata, EXT_FLUSH_GRP);
    base_flush = base_we && paging_on;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q      <= '0;
      ext_q       <= '0;
      flush_all_q <= 1'b0;
      flush_ng_q  <= 1'b0;
    end else begin
      flush_all_q <= ext_change;
      flush_ng_q  <= base_flush;
      if (base_we) base_q <= wdata;
      if (ext_we)  ext_q  <= wdata;
    end
  end

  assert_base_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_ng_q == ($past(base_we) && $past(paging_on)));

  assert_base_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    base_we |=> base_q == $past(wdata));

  assert_ext_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all_q |-> ($past(ext_we) && (((ext_q ^ $past(ext_q)) & EXT_FLUSH_GRP) != '0)));
endmodule

// File: rtl/pgctl_gate_unit.sv
module pgctl_gate_unit
  import pgctl_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         gate,
  output logic [W-1:0] mask_q,
  output logic         flush_q,
  output logic         exit_q
);
  logic gate_moved;

  always_comb gate_moved = gate != mask_q[A20_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '1;
      flush_q <= 1'b0;
      exit_q  <= 1'b0;
    end else begin
      flush_q <= gate_moved;
      exit_q  <= gate_moved;
      if (gate_moved) mask_q <= gate_mask(gate);
    end
  end

  assert_exit_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exit_q |-> (mask_q[A20_BIT] != $past(mask_q[A20_BIT])) && flush_q);

  assert_mask_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q | A20_BIT_MASK) == '1);

  assert_steady_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(mask_q) |-> !exit_q);
endmodule

// File: rtl/pgctl_top.sv
module pgctl_top
  import pgctl_pkg::*;
#(
  parameter int W = REG_W,
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sel,
  input  logic [W-1:0]  wr_data,
  input  logic          a20_gate,
  output logic [W-1:0]  ctl_word,
  output logic [W-1:0]  dir_base,
  output logic [W-1:0]  ext_word,
  output logic [W-1:0]  addr_mask,
  output logic [FLAG_W-1:0] mode_flags,
  output logic          flush_all,
  output logic          flush_keep_global,
  output logic          exec_exit
);
  logic        ctl_we, base_we, ext_we;
  logic        ctl_flush, ext_flush, gate_flush;
  mode_flags_t flags;

  always_comb begin
    ctl_we  = wr_en && (wr_sel == SEL_CTL);
    base_we = wr_en && (wr_sel == SEL_BASE);
    ext_we  = wr_en && (wr_sel == SEL_EXT);
  end

  pgctl_ctl_unit #(.W(W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(wr_data),
    .ctl_q(ctl_word), .flags_q(flags), .flush_q(ctl_flush)
  );

  pgctl_aux_unit #(.W(W)) u_aux (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .ext_we(ext_we),
    .paging_on(ctl_word[CTL_PG_BIT]), .wdata(wr_data),
    .base_q(dir_base), .ext_q(ext_word),
    .flush_all_q(ext_flush), .flush_ng_q(flush_keep_global)
  );

  pgctl_gate_unit #(.W(W)) u_gate (
    .clk(clk), .rst_n(rst_n), .gate(a20_gate),
    .mask_q(addr_mask), .flush_q(gate_flush), .exit_q(exec_exit)
  );

  always_comb begin
    flush_all  = ctl_flush | ext_flush | gate_flush;
    mode_flags = flags;
  end

  assert_spare_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd3) |=> ($stable(ctl_word) && $stable(dir_base) && $stable(ext_word)
                                   && !flush_keep_global));

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(!rst_n) |-> (ctl_word == CTL_RESET && !flush_keep_global && !exec_exit));
endmodule

// File: tb/test_pgctl_top.sv
module test_pgctl_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic        a20_gate;
  logic [31:0] ctl_word, dir_base, ext_word, addr_mask;
  logic [4:0]  mode_flags;
  logic        flush_all, flush_keep_global, exec_exit;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int          due;
    string       tag;
    logic [31:0] ctl, base, ext, mask;
    logic [4:0]  flags;
    logic        fa, fng, ex;
  } exp_t;
  exp_t sb[$];

  // independent model state
  logic [31:0] m_ctl, m_base, m_ext;
  logic        m_gate;
  logic [4:0]  m_flags;

  pgctl_top i_pgctl_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .a20_gate(a20_gate), .ctl_word(ctl_word), .dir_base(dir_base), .ext_word(ext_word),
    .addr_mask(addr_mask), .mode_flags(mode_flags), .flush_all(flush_all),
    .flush_keep_global(flush_keep_global), .exec_exit(exec_exit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  function automatic logic [31:0] exp_mask(input logic g);
    return g ? 32'hFFFF_FFFF : 32'hFFEF_FFFF;
  endfunction

  task automatic step(input logic en, input logic [1:0] sel, input logic [31:0] d,
                      input logic g, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    wr_en = en; wr_sel = sel; wr_data = d; a20_gate = g;
    e.fa = 1'b0; e.fng = 1'b0; e.ex = 1'b0;
    if (en) begin
      if (sel == 2'd0) begin
        e.fa = (m_ctl[31] != d[31]) || (m_ctl[16] != d[16]) || (m_ctl[0] != d[0]);
        m_ctl = {d[31:5], 1'b1, d[3:0]};
        m_flags = {d[3], d[2], d[1], m_flags[1] | ~d[0], d[0]};
      end else if (sel == 2'd1) begin
        e.fng = m_ctl[31];
        m_base = d;
      end else if (sel == 2'd2) begin
        e.fa = (m_ext[7] != d[7]) || (m_ext[5] != d[5]) || (m_ext[4] != d[4]);
        m_ext = d;
      end
    end
    if (g != m_gate) begin
      e.fa = 1'b1; e.ex = 1'b1; m_gate = g;
    end
    e.due = cyc + 1; e.tag = tag;
    e.ctl = m_ctl; e.base = m_base; e.ext = m_ext; e.mask = exp_mask(m_gate);
    e.flags = m_flags;
    sb.push_back(e);
  endtask

  // monitor
  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].due == cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (ctl_word !== e.ctl || dir_base !== e.base || ext_word !== e.ext ||
          addr_mask !== e.mask || mode_flags !== e.flags || flush_all !== e.fa ||
          flush_keep_global !== e.fng || exec_exit !== e.ex) begin
        failures++;
        $display("FAIL %s cyc=%0d: act ctl=%h base=%h ext=%h mask=%h fl=%b fa=%b fng=%b ex=%b exp ctl=%h base=%h ext=%h mask=%h fl=%b fa=%b fng=%b ex=%b",
                 e.tag, cyc, ctl_word, dir_base, ext_word, addr_mask, mode_flags,
                 flush_all, flush_keep_global, exec_exit, e.ctl, e.base, e.ext, e.mask,
                 e.flags, e.fa, e.fng, e.ex);
      end
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: act cycles=%0d exp below %0d", cyc, WD_CYCLES);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0; a20_gate = 1'b1;
    m_ctl = 32'h6000_0010; m_base = '0; m_ext = '0; m_gate = 1'b1; m_flags = 5'b00010;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (ctl_word !== 32'h6000_0010 || dir_base !== 0 || ext_word !== 0 ||
        addr_mask !== 32'hFFFF_FFFF || mode_flags !== 5'b00010 || flush_all !== 0 ||
        flush_keep_global !== 0 || exec_exit !== 0) begin
      failures++;
      $display("FAIL R1 reset: act ctl=%h base=%h ext=%h mask=%h fl=%b pulses=%b%b%b exp 60000010 0 0 ffffffff 00010 000",
               ctl_word, dir_base, ext_word, addr_mask, mode_flags, flush_all,
               flush_keep_global, exec_exit);
    end

    step(1, 2'd0, 32'h6000_0010, 1, "R2 R10 same ctl value");
    step(1, 2'd0, 32'h0000_0001, 1, "R2 R3 R4 PE on, ET forced");
    step(1, 2'd0, 32'h0000_000F, 1, "R5 R10 monitor/emulate/ts bits");
    step(1, 2'd0, 32'h8000_000B, 1, "R3 paging on");
    step(1, 2'd1, 32'h1234_5000, 1, "R6 base write paging on");
    step(1, 2'd1, 32'h1234_5000, 1, "R6 base rewrite paging on");
    step(1, 2'd2, 32'h0000_0008, 1, "R7 ext bit outside group");
    step(1, 2'd2, 32'h0000_0010, 1, "R7 ext bit 4");
    step(1, 2'd2, 32'h0000_0090, 1, "R7 ext bit 7");
    step(1, 2'd3, 32'hFFFF_FFFF, 1, "R9 spare select");
    step(0, 2'd0, 32'h0,         0, "R8 gate drop");
    step(0, 2'd0, 32'h0,         0, "R10 steady gate");
    step(1, 2'd0, 32'h0001_0000, 1, "R8 R4 gate rise with ctl write");
    step(1, 2'd1, 32'hABCD_E000, 1, "R6 base write paging off");
    step(1, 2'd0, 32'h0000_0001, 1, "R10 back-to-back first");
    step(1, 2'd0, 32'h0000_0000, 1, "R10 back-to-back second");
    step(1, 2'd0, 32'h0001_0000, 1, "R3 write protect toggle");
    step(1, 2'd2, 32'h0000_0020, 1, "R7 ext bit 5");
    step(0, 2'd0, 32'h0,         1, "R10 idle");
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      failures++;
      $display("FAIL scoreboard drain: act pending=%0d exp 0", sb.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule